// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Set-Associative TLB

This block turns a processor's virtual address into a physical address. Each request is looked up in a small set-associative cache of recent translations. When the page is present, the physical address comes back on the next cycle with no memory traffic. When it is absent, the block computes where the page's table entry sits, starting from a base-address input. It then issues a single-beat read for that entry and waits for the reply.

A reply whose valid bit is set is written into the translation cache and answers the request. A reply whose valid bit is clear comes back as a fault, and nothing is cached. Only one walk can be in flight at a time. The request port stalls until the walk finishes. A flush input empties the whole cache in one cycle, which is needed whenever the base address changes to another process's table.

Top module: `mmu_xlate`

## Requirements
- R1: A virtual address splits into a page offset (bits 5:0) and a page number (bits 13:6). The page number's low 2 bits select one of 4 sets, and its upper 6 bits are the tag compared in each of the 4 ways of that set.
- R2: A request accepted while its page is cached gives `rsp_valid` exactly one cycle later, with `rsp_hit`=1, `rsp_fault`=0, and no memory read.
- R3: On any non-faulting response, `rsp_pa` bits 5:0 equal the request's offset bits, and `rsp_pa` bits 11:6 carry the physical page number.
- R4: An accepted request that misses raises `mem_req_valid` on the next cycle. `mem_addr` is `ptbase + 2*page_number` (modulo 2^12), and both stay unchanged until `mem_rsp_valid` is seen. Exactly one read is made per miss.
- R5: The table entry is 16 bits: bit 15 is the valid flag, bits 5:0 are the physical page number, and bits 14:6 are ignored. A valid entry produces `rsp_valid` one cycle after `mem_rsp_valid`, with `rsp_hit`=0, and the entry is cached so that the next request to the same page hits.
- R6: An entry with bit 15 clear produces `rsp_valid` with `rsp_fault`=1, `rsp_hit`=0 and `rsp_pa`=0. It is not cached, so a repeat request walks again.
- R7: A refill takes the lowest-numbered empty way of its set. When the set is full, it replaces the way named by that set's rotating pointer, which starts at way 0 and advances by one after each such replacement.
- R8: `req_ready` is low from the cycle after a missing request is accepted until the cycle its response is presented. It is high at all other times.
- R9: A one-cycle `flush` empties every way and returns every rotating pointer to way 0. It takes precedence over a refill in the same cycle.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the translation cache |
| ptbase | input | 12 | Physical base address of the current page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | 14 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 12 | Translated physical address |
| rsp_fault | output | 1 | Page fault: table entry not valid |
| rsp_hit | output | 1 | Response served from the cache |
| mem_req_valid | output | 1 | Table-entry read pending |
| mem_addr | output | 12 | Address of the table entry |
| mem_rsp_valid | input | 1 | Table-entry read data present |
| mem_rdata | input | 16 | Table-entry read data |

## Verification
A hit is due on the first falling edge after the accepting clock edge. A miss is due one edge after the edge that captures `mem_rsp_valid`. With the bench's memory model answering on its third falling edge, a miss response is due four cycles after acceptance. The bench counts falling edges from acceptance and checks that the response strobe appears at exactly that count, along with its hit flag, fault flag and address. It also checks that `req_ready` is already low one edge after a miss is accepted, and that the table read appears with the right address before the model answers.

// File: rtl/mmu_pkg.sv
// Shared types for the address translator.
// Assumes: a single outstanding table walk, so two control states suffice.
package mmu_pkg;
    typedef enum logic {
        XS_IDLE,
        XS_WALK
    } xl_state_e;
endpackage

// File: rtl/tlb_store.sv
// Set-associative translation cache: combinational lookup, single refill port,
// free-way-first then per-set rotating victim, whole-array flush.
// Assumes: refill is only requested for a page that just missed, so a page
// never occupies two ways of its set.
module tlb_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn
);

    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];

    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] victim;
    logic             have_free;
    logic             any_valid;

    // Per-way tag compare in the addressed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign lk_hit = |hit_vec;

    // Merge the frame number of the matching way.
    always_comb begin
        lk_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) lk_ppn = lk_ppn | ppn_q[lk_set][w];
        end
    end

    // Choose the refill way: lowest empty way, else the rotating pointer.
    always_comb begin
        have_free = 1'b0;
        victim    = rr_q[wr_set];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[wr_set][w]) begin
                have_free = 1'b1;
                victim    = WAY_W'(w);
            end
        end
    end

    // Valid bits and rotating pointers, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_set][victim] <= 1'b1;
            if (!have_free) rr_q[wr_set] <= rr_q[wr_set] + 1'b1;
        end
    end

    // Tag and frame storage, written on refill only.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_set][victim] <= wr_tag;
            ppn_q[wr_set][victim] <= wr_ppn;
        end
    end

    // Reduction of all valid bits for the flush check.
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
    end

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !any_valid);

endmodule

// File: rtl/xlate_ctrl.sv
// Request sequencing: serves hits from the cache in one cycle, otherwise
// reads the page-table entry, then refills or reports a fault.
// Assumes: memory holds mem_rdata valid for the cycle mem_rsp_valid is high,
// and frame-number width plus offset width equals the physical width.
module xlate_ctrl
    import mmu_pkg::*;
#(
    parameter int VA_W   = 14,
    parameter int PA_W   = 12,
    parameter int OFF_W  = 6,
    parameter int SET_W  = 2,
    parameter int TAG_W  = 6,
    parameter int PPN_W  = 6,
    parameter int PTE_W  = 16,
    parameter int PTE_SH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic [PA_W-1:0]  ptbase,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_fault,
    output logic             rsp_hit,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic [SET_W-1:0] lk_set,
    output logic [TAG_W-1:0] lk_tag,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    output logic             wr_en,
    output logic [SET_W-1:0] wr_set,
    output logic [TAG_W-1:0] wr_tag,
    output logic [PPN_W-1:0] wr_ppn
);

    xl_state_e       state_q;
    logic [VA_W-1:0] va_q;
    logic            accept;
    logic            pte_ok;
    logic            unused_pte;

    assign req_ready  = (state_q == XS_IDLE);
    assign accept     = req_valid && req_ready;
    assign pte_ok     = mem_rdata[PTE_W-1];
    assign unused_pte = ^mem_rdata[PTE_W-2:PPN_W];

    // Lookup fields come straight from the incoming address.
    assign lk_set = req_va[OFF_W +: SET_W];
    assign lk_tag = req_va[OFF_W + SET_W +: TAG_W];

    // Refill fields come from the captured address and the fetched entry.
    assign wr_en  = (state_q == XS_WALK) && mem_rsp_valid && pte_ok;
    assign wr_set = va_q[OFF_W +: SET_W];
    assign wr_tag = va_q[OFF_W + SET_W +: TAG_W];
    assign wr_ppn = mem_rdata[PPN_W-1:0];

    // Control state, response registers and table-read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= XS_IDLE;
            va_q          <= '0;
            rsp_valid     <= 1'b0;
            rsp_pa        <= '0;
            rsp_fault     <= 1'b0;
            rsp_hit       <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_addr      <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_hit   <= 1'b0;
            case (state_q)
                XS_IDLE: begin
                    if (accept) begin
                        va_q <= req_va;
                        if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_pa    <= {lk_ppn, req_va[OFF_W-1:0]};
                        end else begin
                            state_q       <= XS_WALK;
                            mem_req_valid <= 1'b1;
                            mem_addr      <= ptbase + (PA_W'(req_va[VA_W-1:OFF_W]) << PTE_SH);
                        end
                    end
                end
                XS_WALK: begin
                    if (mem_rsp_valid) begin
                        state_q       <= XS_IDLE;
                        mem_req_valid <= 1'b0;
                        rsp_valid     <= 1'b1;
                        if (pte_ok) begin
                            rsp_pa <= {mem_rdata[PPN_W-1:0], va_q[OFF_W-1:0]};
                        end else begin
                            rsp_fault <= 1'b1;
                            rsp_pa    <= '0;
                        end
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (rsp_valid && rsp_hit));

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]));

    assert_walk_from_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(accept && !lk_hit));

    assert_read_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_addr)));

    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && !rsp_hit && rsp_pa == '0));

    assert_stall_on_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

endmodule

// File: rtl/mmu_xlate.sv
// Top of the translator: derives field widths from the address geometry
// and joins the sequencer to the translation cache.
// Assumes: page size and entry size are powers of two.
module mmu_xlate #(
    parameter int VA_W       = 14,
    parameter int PA_W       = 12,
    parameter int PAGE_BYTES = 64,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int PTE_BYTES  = 2,
    parameter int PTE_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PA_W-1:0]  ptbase,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_fault,
    output logic             rsp_hit,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rdata
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = VPN_W - SET_W;
    localparam int PTE_SH = $clog2(PTE_BYTES);

    logic [SET_W-1:0] lk_set, wr_set;
    logic [TAG_W-1:0] lk_tag, wr_tag;
    logic [PPN_W-1:0] lk_ppn, wr_ppn;
    logic             lk_hit, wr_en;

    xlate_ctrl #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .SET_W(SET_W),
        .TAG_W(TAG_W), .PPN_W(PPN_W), .PTE_W(PTE_W), .PTE_SH(PTE_SH)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .ptbase(ptbase),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_hit(rsp_hit),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .lk_set(lk_set), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .wr_en(wr_en), .wr_set(wr_set), .wr_tag(wr_tag), .wr_ppn(wr_ppn)
    );

    tlb_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)
    ) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_set(lk_set), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .wr_en(wr_en), .wr_set(wr_set), .wr_tag(wr_tag), .wr_ppn(wr_ppn)
    );

endmodule

// File: tb/mmu_xlate_tb.sv
// Self-checking bench: a page-table memory model computed from a formula,
// directed hit/miss/fault/replacement/flush cases, then a sweep of all pages.
module mmu_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n, flush, req_valid, mem_rsp_valid;
    logic [11:0] ptbase;
    logic [13:0] req_va;
    logic [15:0] mem_rdata;
    logic        req_ready, rsp_valid, rsp_fault, rsp_hit, mem_req_valid;
    logic [11:0] rsp_pa, mem_addr;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          mem_reads = 0;
    int          wcnt = 0;
    int          cur_v = 0;
    logic [11:0] exp_addr = '0;

    always #10 clk = ~clk;

    mmu_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ptbase(ptbase),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_hit(rsp_hit),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
    );

    // Table entry for page v: valid flag bit 15, frame bits 5:0, junk in 14:6.
    function automatic logic [15:0] pte_of(input int v);
        logic [5:0] f;
        logic       ok;
        ok = ((v % 7) != 3);
        f  = 6'((v * 13 + 5) & 63);
        if (v == 0)  begin ok = 1'b1; f = 6'h28; end
        if (v == 15) begin ok = 1'b1; f = 6'h0D; end
        return {ok, 9'((v * 37) & 511), f};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Memory model: answers a table read on the third falling edge it sees it.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rdata     = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
            end else if (mem_req_valid) begin
                if (wcnt == 2) begin
                    wcnt = 0;
                    chk(mem_addr == exp_addr, "R4", "entry address", int'(mem_addr), int'(exp_addr));
                    mem_rdata     = pte_of(cur_v);
                    mem_rsp_valid = 1'b1;
                    mem_reads++;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // Issue one translation and check timing, flags and address.
    task automatic xlate(input logic [13:0] va, input bit exp_hit, input string rq);
        logic [15:0] p;
        logic [11:0] epa;
        bit          flt;
        int          cyc;
        int          r0;
        cur_v    = int'(va[13:6]);
        p        = pte_of(cur_v);
        flt      = !exp_hit && !p[15];
        epa      = flt ? 12'h000 : {p[5:0], va[5:0]};
        exp_addr = ptbase + 12'(2 * cur_v);
        r0       = mem_reads;
        chk(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
        req_va    = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        if (!exp_hit) chk(req_ready == 1'b0, "R8", "ready during walk", int'(req_ready), 0);
        while (!rsp_valid && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid == 1'b1, rq, "response strobe", int'(rsp_valid), 1);
        chk(cyc == (exp_hit ? 1 : 4), rq, "response latency", cyc, exp_hit ? 1 : 4);
        chk(rsp_hit == exp_hit, "R2", "hit flag", int'(rsp_hit), int'(exp_hit));
        chk(rsp_fault == flt, "R6", "fault flag", int'(rsp_fault), int'(flt));
        chk(rsp_pa == epa, "R3", "physical address", int'(rsp_pa), int'(epa));
        chk(mem_reads - r0 == (exp_hit ? 0 : 1), "R4", "table reads", mem_reads - r0, exp_hit ? 0 : 1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, rq, "strobe is one cycle", int'(rsp_valid), 0);
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_va = '0; ptbase = '0;
        repeat (3) @(negedge clk);
        // R10: state held by reset
        chk(req_ready == 1'b1, "R10", "ready in reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R10", "no response in reset", int'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R10", "no read in reset", int'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 then R2: page 0x0F refilled by a walk, then hits with frame 0x0D
        xlate(14'h03D4, 1'b0, "R5");
        xlate(14'h03D4, 1'b1, "R2");
        xlate(14'h03C0, 1'b1, "R3");
        // R5: page 0x00 resolved by the table to frame 0x28
        xlate(14'h0020, 1'b0, "R5");
        xlate(14'h0021, 1'b1, "R2");
        // R1: same set as page 0x0F, different tag, must miss
        xlate({8'h13, 6'h05}, 1'b0, "R1");
        xlate({8'h0F, 6'h3F}, 1'b1, "R1");

        // R6: page 3 has a clear valid flag; it faults and is never cached
        xlate({8'h03, 6'h11}, 1'b0, "R6");
        xlate({8'h03, 6'h11}, 1'b0, "R6");

        // R9: flush drops cached pages
        pulse_flush();
        xlate(14'h03D4, 1'b0, "R9");
        xlate(14'h0020, 1'b0, "R9");

        // R7: fill set 0 with pages 0,4,8,12, then evict in rotation
        pulse_flush();
        xlate({8'd0,  6'h01}, 1'b0, "R7");
        xlate({8'd4,  6'h02}, 1'b0, "R7");
        xlate({8'd8,  6'h03}, 1'b0, "R7");
        xlate({8'd12, 6'h04}, 1'b0, "R7");
        xlate({8'd0,  6'h05}, 1'b1, "R7");
        xlate({8'd4,  6'h06}, 1'b1, "R7");
        xlate({8'd8,  6'h07}, 1'b1, "R7");
        xlate({8'd12, 6'h08}, 1'b1, "R7");
        xlate({8'd16, 6'h09}, 1'b0, "R7");
        xlate({8'd0,  6'h0A}, 1'b0, "R7");
        xlate({8'd8,  6'h0B}, 1'b1, "R7");
        xlate({8'd12, 6'h0C}, 1'b1, "R7");
        xlate({8'd16, 6'h0D}, 1'b1, "R7");
        xlate({8'd0,  6'h0E}, 1'b1, "R7");
        xlate({8'd4,  6'h0F}, 1'b0, "R7");
        xlate({8'd8,  6'h10}, 1'b0, "R7");

        // R4: sweep every page with a moved table base
        ptbase = 12'h400;
        for (int v = 0; v < 256; v++) begin
            pulse_flush();
            xlate({8'(v), 6'((v * 11) & 63)}, 1'b0, "R4");
            xlate({8'(v), 6'((v * 29) & 63)}, pte_of(v)[15], "R5");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule